// File: doc/BRIEF.md
# Display Partition Scan Address Generator

This block keeps the display-memory scan address for a single display partition of a raster graphics controller. When the partition load strobe fires, it captures the partition's four parameter bytes from a 32-bit parameter RAM read word. From those bytes it takes the start address, the partition length, the width flag and the half-step flag. The scan address is set from the start address. In text mode the address is cut to 13 bits and half-step is forced off.

Each next-line strobe advances a 5-bit row line counter. When the counter reaches the programmed row height, the counter returns to zero and the scan address moves on by the display pitch. If half-step is set, it moves by half the pitch instead. This is how a graphics partition shared with text steps through memory at half rate. The surrounding controller reads the scan address, the length and the flags from registered outputs.

Top module: `partition_scan_addr`

## Requirements
- R1: After reset the scan address is 0, the length is 0x3FF, and the width flag and half-step flag are both 0.
- R2: The parameter word carries byte 0 in bits [7:0], byte 1 in [15:8], byte 2 in [23:16] and byte 3 in [31:24]. In graphics mode (text_mode_i = 0), a load sets the scan address to {byte2[1:0], byte1, byte0} on the clock edge that samples the strobe.
- R3: A load sets the length to {byte3[5:0], byte2[7:4]} and the width flag to byte3 bit 7.
- R4: A graphics-mode load sets the half-step flag to byte3 bit 6.
- R5: A text-mode load (text_mode_i = 1) clears the half-step flag and keeps only bits [12:0] of the assembled start address. All higher address bits become 0.
- R6: Each next-line strobe increments the row line counter. The scan address changes only on the strobe that brings the counter to the row height. A row height of 0 counts as 32.
- R7: At a row boundary the scan address grows by pitch_i when the half-step flag is 0. It grows by pitch_i shifted right by one when the flag is 1.
- R8: A load and a next-line strobe in the same cycle act as a load alone. Every load also returns the row line counter to 0.
- R9: Address addition wraps modulo 2^18 with no saturation.
- R10: In a cycle with neither strobe, the scan address holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prm_word_i | input | 32 | Parameter RAM read word, bytes 0..3 from low to high |
| text_mode_i | input | 1 | 1 = text partition, 0 = graphics partition |
| load_i | input | 1 | Partition load strobe |
| line_i | input | 1 | Next-line strobe |
| pitch_i | input | 10 | Display pitch in address units |
| row_height_i | input | 5 | Lines per row, 0 means 32 |
| scan_addr_o | output | 18 | Current scan address |
| length_o | output | 10 | Partition length |
| wide_o | output | 1 | Width flag |
| half_step_o | output | 1 | Half-rate address advance flag |

## Verification
The bench uses an odd pitch with half-step set. A design that rounds up, or that ignores the flag, lands one unit or a full half-row away from the expected address. It then reloads the same word in text mode: a design without the 13-bit mask keeps the high start bits, and one that does not force the flag off keeps advancing at half rate. A row height of 0 must take 32 strobes. A design that compares only in 5 bits would never advance, or would advance after a single line. Other directed cases cover an address sum that overflows 18 bits, where a saturating design sticks at the top. They also fire load and next-line together partway through a row: if the line strobe wins, or the counter is not cleared, the next boundary comes early.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic {
    MODE_GFX  = 1'b0,
    MODE_TEXT = 1'b1
  } part_mode_e;

  localparam int BYTE_W      = 8;
  localparam int PRM_BYTES   = 4;
  localparam int PRM_W       = BYTE_W * PRM_BYTES;
  localparam int START_HI_W  = 2;
  localparam int START_W     = 2 * BYTE_W + START_HI_W;
  localparam int LEN_LO_W    = 4;
  localparam int LEN_HI_W    = 6;
  localparam int FLD_LEN_W   = LEN_LO_W + LEN_HI_W;
  localparam int WIDE_BIT    = 7;
  localparam int HALF_BIT    = 6;

  typedef struct packed {
    logic [START_W-1:0]   start;
    logic [FLD_LEN_W-1:0] len;
    logic                 wide;
    logic                 half;
  } part_cfg_t;
endpackage

// File: rtl/prm_field_decode.sv
module prm_field_decode
  import scan_pkg::*;
(
  input  logic [PRM_W-1:0] word_i,
  output part_cfg_t        cfg_o
);
  logic [BYTE_W-1:0] b [PRM_BYTES];

  for (genvar gi = 0; gi < PRM_BYTES; gi++) begin : g_bytes
    assign b[gi] = word_i[gi*BYTE_W +: BYTE_W];
  end

  always_comb begin
    cfg_o.start = {b[2][START_HI_W-1:0], b[1], b[0]};
    cfg_o.len   = {b[3][LEN_HI_W-1:0], b[2][BYTE_W-1 -: LEN_LO_W]};
    cfg_o.wide  = b[3][WIDE_BIT];
    cfg_o.half  = b[3][HALF_BIT];
  end
endmodule

// File: rtl/row_line_counter.sv
module row_line_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] height_i,
  output logic             row_end_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int EXT_W = CNT_W + 1;
  localparam logic [EXT_W-1:0] FULL_ROW = EXT_W'(1) << CNT_W;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] cnt_inc;
  logic [EXT_W-1:0] limit;

  always_comb begin
    cnt_inc   = {1'b0, cnt_q} + EXT_W'(1);
    limit     = (height_i == '0) ? FULL_ROW : {1'b0, height_i};
    row_end_o = step_i && (cnt_inc == limit);
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= row_end_o ? '0 : cnt_inc[CNT_W-1:0];
    end
  end

  assign cnt_o = cnt_q;

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0));

  assert_count_R6: assert property (@(posedge clk) disable iff (rst)
    (step_i && !clr_i && !row_end_o) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    row_end_o |=> (cnt_q == '0));
endmodule

// File: rtl/scan_addr_reg.sv
module scan_addr_reg #(
  parameter int ADDR_W  = 18,
  parameter int PITCH_W = 10,
  parameter int TEXT_W  = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [ADDR_W-1:0]  load_val_i,
  input  logic               text_i,
  input  logic               adv_i,
  input  logic               half_i,
  input  logic [PITCH_W-1:0] pitch_i,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam logic [ADDR_W-1:0] TEXT_MASK = (ADDR_W'(1) << TEXT_W) - ADDR_W'(1);

  logic [ADDR_W-1:0]  addr_q;
  logic [PITCH_W-1:0] step;

  always_comb begin
    step = half_i ? (pitch_i >> 1) : pitch_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (load_i) begin
      addr_q <= text_i ? (load_val_i & TEXT_MASK) : load_val_i;
    end else if (adv_i) begin
      addr_q <= addr_q + ADDR_W'(step);
    end
  end

  assign addr_o = addr_q;

  assert_text_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (load_i && text_i) |=> (addr_q[ADDR_W-1:TEXT_W] == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_i) |=> $stable(addr_q));
endmodule

// File: rtl/partition_scan_addr.sv
module partition_scan_addr
  import scan_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int PITCH_W = 10,
  parameter int ROW_W   = 5,
  parameter int TEXT_W  = 13
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [31:0]          prm_word_i,
  input  logic                 text_mode_i,
  input  logic                 load_i,
  input  logic                 line_i,
  input  logic [PITCH_W-1:0]   pitch_i,
  input  logic [ROW_W-1:0]     row_height_i,
  output logic [ADDR_W-1:0]    scan_addr_o,
  output logic [FLD_LEN_W-1:0] length_o,
  output logic                 wide_o,
  output logic                 half_step_o
);
  localparam logic [FLD_LEN_W-1:0] LEN_RST = '1;

  part_cfg_t        cfg;
  part_mode_e       mode;
  logic             row_end;
  logic [ROW_W-1:0] row_cnt;
  logic [FLD_LEN_W-1:0] len_q;
  logic             wide_q;
  logic             half_q;

  assign mode = part_mode_e'(text_mode_i);

  prm_field_decode u_decode (
    .word_i (prm_word_i),
    .cfg_o  (cfg)
  );

  row_line_counter #(.CNT_W(ROW_W)) u_rows (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (load_i),
    .step_i    (line_i),
    .height_i  (row_height_i),
    .row_end_o (row_end),
    .cnt_o     (row_cnt)
  );

  scan_addr_reg #(
    .ADDR_W  (ADDR_W),
    .PITCH_W (PITCH_W),
    .TEXT_W  (TEXT_W)
  ) u_addr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .load_val_i (ADDR_W'(cfg.start)),
    .text_i     (mode == MODE_TEXT),
    .adv_i      (row_end && !load_i),
    .half_i     (half_q),
    .pitch_i    (pitch_i),
    .addr_o     (scan_addr_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= LEN_RST;
      wide_q <= 1'b0;
      half_q <= 1'b0;
    end else if (load_i) begin
      len_q  <= cfg.len;
      wide_q <= cfg.wide;
      half_q <= (mode == MODE_TEXT) ? 1'b0 : cfg.half;
    end
  end

  assign length_o    = len_q;
  assign wide_o      = wide_q;
  assign half_step_o = half_q;

  assert_text_half_R5: assert property (@(posedge clk) disable iff (rst)
    (load_i && text_mode_i) |=> !half_step_o);

  assert_gfx_half_R4: assert property (@(posedge clk) disable iff (rst)
    (load_i && !text_mode_i) |=> (half_step_o == $past(prm_word_i[24 + HALF_BIT])));

  assert_advance_R7: assert property (@(posedge clk) disable iff (rst)
    (row_end && !load_i) |=> (scan_addr_o == $past(scan_addr_o)
      + ADDR_W'($past(half_step_o) ? ($past(pitch_i) >> 1) : $past(pitch_i))));

  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(length_o) && $stable(wide_o) && $stable(half_step_o)));

  assert_no_row_end_R6: assert property (@(posedge clk) disable iff (rst)
    (row_end && line_i) |-> (row_cnt != '1 || row_height_i == '0));
endmodule

// File: tb/partition_scan_addr_bench.sv
module partition_scan_addr_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] prm_word = '0;
  logic        text_mode = 1'b0;
  logic        load = 1'b0;
  logic        line = 1'b0;
  logic [9:0]  pitch = '0;
  logic [4:0]  height = '0;
  logic [17:0] scan_addr;
  logic [9:0]  length;
  logic        wide;
  logic        half_step;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  partition_scan_addr u_partition_scan_addr (
    .clk          (clk),
    .rst          (rst),
    .prm_word_i   (prm_word),
    .text_mode_i  (text_mode),
    .load_i       (load),
    .line_i       (line),
    .pitch_i      (pitch),
    .row_height_i (height),
    .scan_addr_o  (scan_addr),
    .length_o     (length),
    .wide_o       (wide),
    .half_step_o  (half_step)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [31:0] w, input logic txt, input logic with_line);
    @(negedge clk);
    prm_word  = w;
    text_mode = txt;
    load      = 1'b1;
    line      = with_line;
    @(negedge clk);
    load = 1'b0;
    line = 1'b0;
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line = 1'b1;
      @(negedge clk);
      line = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R1 addr", 32'(scan_addr), 32'h0);
    chk("R1 length", 32'(length), 32'h3FF);
    chk("R1 wide", 32'(wide), 32'h0);
    chk("R1 half", 32'(half_step), 32'h0);
  endtask

  task automatic t_gfx_load();
    do_load(32'hC5A3_1234, 1'b0, 1'b0);
    chk("R2 start", 32'(scan_addr), 32'h31234);
    chk("R3 length", 32'(length), 32'h05A);
    chk("R3 wide", 32'(wide), 32'h1);
    chk("R4 half", 32'(half_step), 32'h1);
    do_load(32'h0F03_0000, 1'b0, 1'b0);
    chk("R3 length2", 32'(length), 32'h0F0);
    chk("R3 wide2", 32'(wide), 32'h0);
    chk("R4 half2", 32'(half_step), 32'h0);
    chk("R2 start2", 32'(scan_addr), 32'h30000);
  endtask

  task automatic t_half_step();
    do_load(32'hC5A3_1234, 1'b0, 1'b0);
    pitch  = 10'h051;
    height = 5'd4;
    lines(3);
    chk("R6 mid row", 32'(scan_addr), 32'h31234);
    repeat (3) @(negedge clk);
    chk("R10 idle hold", 32'(scan_addr), 32'h31234);
    lines(1);
    chk("R7 half advance", 32'(scan_addr), 32'h3125C);
  endtask

  task automatic t_text();
    do_load(32'hC5A3_1234, 1'b1, 1'b0);
    chk("R5 mask", 32'(scan_addr), 32'h01234);
    chk("R5 half off", 32'(half_step), 32'h0);
    pitch  = 10'h050;
    height = 5'd4;
    lines(4);
    chk("R7 full advance", 32'(scan_addr), 32'h01284);
  endtask

  task automatic t_height_zero();
    do_load(32'h05A3_1234, 1'b0, 1'b0);
    pitch  = 10'h050;
    height = 5'd0;
    lines(31);
    chk("R6 height0 31 lines", 32'(scan_addr), 32'h31234);
    lines(1);
    chk("R6 height0 32 lines", 32'(scan_addr), 32'h31284);
  endtask

  task automatic t_wrap();
    do_load(32'h0003_FFF0, 1'b0, 1'b0);
    pitch  = 10'h3FF;
    height = 5'd1;
    lines(1);
    chk("R9 wrap", 32'(scan_addr), 32'h003EF);
  endtask

  task automatic t_priority();
    do_load(32'h0001_0000, 1'b0, 1'b0);
    pitch  = 10'h010;
    height = 5'd4;
    lines(2);
    do_load(32'h0002_0000, 1'b0, 1'b1);
    chk("R8 load wins", 32'(scan_addr), 32'h20000);
    lines(3);
    chk("R8 counter cleared", 32'(scan_addr), 32'h20000);
    lines(1);
    chk("R8 boundary after clear", 32'(scan_addr), 32'h20010);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_gfx_load();
    t_half_step();
    t_text();
    t_height_zero();
    t_wrap();
    t_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule